// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small processor core. The low four bits are arithmetic flags: carry, half carry, zero and signed overflow. The ALU refreshes them through per-flag update strobes, and software can also overwrite them with an ordinary data write. The next two bits are system flags that record a sleep entry and a watchdog expiry. Software writes can never change them. They move only on power-up, on the halt and clear-watchdog instructions, and on a watchdog expiry event.

The register sits at data address 0x0A. A write whose address matches loads the arithmetic flags. A read at that address returns the whole word, and a read at any other address returns zero from this block. The register is not saved by hardware on interrupt entry or on a subroutine call. Firmware must save it if the contents matter.

Top module: `status_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all six flags clear to 0, so a read at 0x0A returns 0x00.
- R2: `rd_data` bits 7 and 6 are always 0. A read with `rd_addr` = 0x0A returns {2'b00, TO, PDF, OV, Z, AC, C} with C at bit 0 and TO at bit 5. Any other `rd_addr` returns 0x00.
- R3: A write with `wr_en` = 1 and `wr_addr` = 0x0A loads `wr_data` bits 3:0 into C, AC, Z and OV from the next edge on. A write to any other address changes no flag.
- R4: No software write changes PDF (bit 4) or TO (bit 5), whatever `wr_data` holds.
- R5: A `halt_ev` pulse sets PDF and clears TO.
- R6: A `clr_wdt_ev` pulse clears PDF and TO. If `halt_ev` arrives in the same cycle, PDF is set instead.
- R7: A `wdt_ev` pulse sets TO. It wins over `halt_ev` and `clr_wdt_ev` in the same cycle.
- R8: For each arithmetic flag whose `alu_we` bit is 1, the flag takes the matching `alu_flags` bit. This takes priority over a software write in the same cycle.
- R9: With no reset, no event, no matching write and no ALU strobe, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| wr_en | input | 1 | Data-memory write strobe |
| wr_addr | input | 8 | Data-memory write address |
| wr_data | input | 8 | Write data |
| alu_we | input | 4 | Per-flag ALU update strobes {OV,Z,AC,C} |
| alu_flags | input | 4 | ALU flag results {OV,Z,AC,C} |
| halt_ev | input | 1 | Halt instruction executed |
| clr_wdt_ev | input | 1 | Clear-watchdog instruction executed |
| wdt_ev | input | 1 | Watchdog time-out |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data |

## Verification
Every flag is one register stage from its inputs, and the read port is combinational from `rd_addr` and that state. An input driven before a rising edge therefore shows on `rd_data` right after that edge. The bench drives all inputs on the falling edge. It compares `rd_data` on the next falling edge against a model advanced once per step, with the address applied in the same cycle. This keeps every expected value aligned to the single edge that produces it.

// File: rtl/status_pkg.sv
// Shared bit positions and widths for the status flag register.
package status_pkg;
    localparam int ARITH_N = 4;
    localparam int BIT_C   = 0;
    localparam int BIT_AC  = 1;
    localparam int BIT_Z   = 2;
    localparam int BIT_OV  = 3;
    localparam int BIT_PDF = 4;
    localparam int BIT_TO  = 5;
    localparam int USED_N  = 6;
endpackage

// File: rtl/stat_arith_flags.sv
// Arithmetic flag bank: one flop per flag.
// Assumes: alu_we bit i beats a software write for flag i; synchronous active-low reset.
module stat_arith_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_we,
    input  logic [N-1:0] sw_val,
    input  logic [N-1:0] alu_we,
    input  logic [N-1:0] alu_val,
    output logic [N-1:0] flags_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-flag update: reset, then ALU, then software, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (alu_we[i])  flags_q[i] <= alu_val[i];
            else if (sw_we)      flags_q[i] <= sw_val[i];
        end

        // R8: ALU strobe value lands on the next edge.
        a_r8_alu_wins: assert property (@(posedge clk) disable iff (!rst_n)
            alu_we[i] |=> flags_q[i] == $past(alu_val[i]));
    end

    // R9: without any strobe, the flags hold.
    a_r9_arith_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && alu_we == '0) |=> $stable(flags_q));
endmodule

// File: rtl/stat_sys_flags.sv
// System flags: power-down (pdf_q) and time-out (to_q).
// Assumes: events are single-cycle pulses; watchdog beats halt/clear for TO,
// halt beats clear for PDF; synchronous active-low reset.
module stat_sys_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_ev,
    input  logic clr_wdt_ev,
    input  logic wdt_ev,
    output logic pdf_q,
    output logic to_q
);
    // Power-down flag: set by halt, cleared by clear-watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n)          pdf_q <= 1'b0;
        else if (halt_ev)    pdf_q <= 1'b1;
        else if (clr_wdt_ev) pdf_q <= 1'b0;
    end

    // Time-out flag: set by expiry, cleared by halt or clear-watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n)                     to_q <= 1'b0;
        else if (wdt_ev)                to_q <= 1'b1;
        else if (halt_ev || clr_wdt_ev) to_q <= 1'b0;
    end

    a_r5_halt_sets_pdf: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ev |=> pdf_q);
    a_r6_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt_ev && !halt_ev && !wdt_ev) |=> (!pdf_q && !to_q));
    a_r7_wdt_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ev |=> to_q);
endmodule

// File: rtl/status_reg.sv
// Status flag register top: address decode, flag banks, read mux.
// Assumes: single-cycle write strobe; read is combinational from state.
module status_reg #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        alu_we,
    input  logic [3:0]        alu_flags,
    input  logic              halt_ev,
    input  logic              clr_wdt_ev,
    input  logic              wdt_ev,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    import status_pkg::*;
    localparam int PAD_W = DATA_W - USED_N;

    logic                wr_hit;
    logic [ARITH_N-1:0]  arith_q;
    logic                pdf_q;
    logic                to_q;
    logic [DATA_W-1:0]   stat_word;

    assign wr_hit = wr_en && (wr_addr == STAT_ADDR);

    stat_arith_flags #(.N(ARITH_N)) u_arith (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (wr_hit),
        .sw_val  (wr_data[ARITH_N-1:0]),
        .alu_we  (alu_we),
        .alu_val (alu_flags),
        .flags_q (arith_q)
    );

    stat_sys_flags u_sys (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_ev    (halt_ev),
        .clr_wdt_ev (clr_wdt_ev),
        .wdt_ev     (wdt_ev),
        .pdf_q      (pdf_q),
        .to_q       (to_q)
    );

    // Assemble the architectural word with unused bits tied low.
    always_comb begin
        stat_word = {{PAD_W{1'b0}}, to_q, pdf_q, arith_q};
    end

    // Read mux: the word at the mapped address, zero elsewhere.
    always_comb begin
        rd_data = (rd_addr == STAT_ADDR) ? stat_word : '0;
    end

    // R1: reset leaves a cleared word.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (arith_q == '0 && !pdf_q && !to_q));
    // R2: the padding bits never read as 1.
    always_comb begin
        a_r2_pad_zero: assert (rd_data[DATA_W-1:USED_N] == '0);
    end
    // R3: a matched write with no ALU strobe loads the arithmetic flags.
    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && alu_we == '0) |=> arith_q == $past(wr_data[ARITH_N-1:0]));
    // R4: writes alone never move the system flags.
    a_r4_sys_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !halt_ev && !clr_wdt_ev && !wdt_ev) |=> ($stable(pdf_q) && $stable(to_q)));
endmodule

// File: tb/sim_status_reg.sv
// Randomised and directed bench for status_reg; compares against a bench model.
module sim_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] alu_we = '0;
    logic [3:0] alu_flags = '0;
    logic       halt_ev = 1'b0;
    logic       clr_wdt_ev = 1'b0;
    logic       wdt_ev = 1'b0;
    logic [7:0] rd_addr = 8'h0A;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [5:0] model = '0;

    always #5 clk = ~clk;

    status_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alu_we(alu_we), .alu_flags(alu_flags),
        .halt_ev(halt_ev), .clr_wdt_ev(clr_wdt_ev), .wdt_ev(wdt_ev),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Expected next state from the requirements.
    function automatic logic [5:0] next_state(
        logic [5:0] s, logic rn, logic we, logic [7:0] wa, logic [7:0] wd,
        logic [3:0] aw, logic [3:0] af, logic h, logic c, logic w);
        logic [5:0] n;
        n = s;
        if (!rn) return 6'd0;
        for (int i = 0; i < 4; i++) begin
            if (aw[i])                    n[i] = af[i];
            else if (we && wa == 8'h0A)   n[i] = wd[i];
        end
        if (h)      n[4] = 1'b1;
        else if (c) n[4] = 1'b0;
        if (w)           n[5] = 1'b1;
        else if (h || c) n[5] = 1'b0;
        return n;
    endfunction

    function automatic logic [7:0] read_val(logic [5:0] s, logic [7:0] ra);
        return (ra == 8'h0A) ? {2'b00, s} : 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%02h expected %02h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample at the following negedge.
    task automatic step(string tag, logic rn, logic we, logic [7:0] wa, logic [7:0] wd,
                        logic [3:0] aw, logic [3:0] af, logic h, logic c, logic w,
                        logic [7:0] ra);
        logic [5:0] prev;
        @(negedge clk);
        rst_n = rn; wr_en = we; wr_addr = wa; wr_data = wd; alu_we = aw;
        alu_flags = af; halt_ev = h; clr_wdt_ev = c; wdt_ev = w; rd_addr = ra;
        prev = model;
        model = next_state(model, rn, we, wa, wd, aw, af, h, c, w);
        @(negedge clk);
        check(tag, rd_data, read_val(model, ra));
        check("R2", {6'd0, rd_data[7:6]}, 8'h00);
        if (rn && we && !h && !c && !w)
            check("R4", {6'd0, rd_addr == 8'h0A ? rd_data[5:4] : prev[5:4]}, {6'd0, prev[5:4]});
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: bench hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state.
        step("R1", 0, 1, 8'h0A, 8'hFF, 4'hF, 4'hF, 1, 0, 1, 8'h0A);
        // R3/R4: write all ones, system flags stay clear.
        step("R3", 1, 1, 8'h0A, 8'hFF, 4'h0, 4'h0, 0, 0, 0, 8'h0A);
        // R3: write to another address has no effect.
        step("R3", 1, 1, 8'h0B, 8'h00, 4'h0, 4'h0, 0, 0, 0, 8'h0A);
        // R2: other read address returns zero.
        step("R2", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 0, 8'h0B);
        // R5: halt sets PDF.
        step("R5", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 0, 0, 8'h0A);
        // R4: write cannot clear PDF.
        step("R4", 1, 1, 8'h0A, 8'h00, 4'h0, 4'h0, 0, 0, 0, 8'h0A);
        // R7: expiry sets TO.
        step("R7", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 1, 8'h0A);
        // R6: clear-watchdog clears both.
        step("R6", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 1, 0, 8'h0A);
        // R7: expiry beats clear-watchdog.
        step("R7", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 1, 1, 8'h0A);
        // R6: halt beats clear for PDF, TO cleared.
        step("R6", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 1, 0, 8'h0A);
        // R8: ALU beats write on strobed flags.
        step("R8", 1, 1, 8'h0A, 8'h0F, 4'h5, 4'h0, 0, 0, 0, 8'h0A);
        // R9: idle holds.
        step("R9", 1, 0, 8'h0A, 8'h00, 4'h0, 4'hF, 0, 0, 0, 8'h0A);
        // Random mix.
        for (int k = 0; k < 2000; k++) begin
            logic [7:0] r;
            logic h, c, w, we;
            logic [3:0] aw;
            string tag;
            r  = 8'($urandom);
            h  = ($urandom % 8) == 0;
            c  = ($urandom % 8) == 0;
            w  = ($urandom % 8) == 0;
            we = ($urandom % 2) == 0;
            aw = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            if (w) tag = "R7"; else if (h) tag = "R5"; else if (c) tag = "R6";
            else if (aw != 0) tag = "R8"; else if (we) tag = "R3"; else tag = "R9";
            step(tag, ($urandom % 50) != 0, we, (r[0] ? 8'h0A : 8'($urandom)),
                 8'($urandom), aw, 4'($urandom), h, c, w,
                 (r[1] | r[2]) ? 8'h0A : 8'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule